// File: doc/BRIEF.md
# Smart Card Bit Clock Generator

This block turns the peripheral clock into the timing signals of a smart-card serial link. It takes an 8-bit divisor N and a 2-bit prescale select n. From these it makes a card clock whose period is 2·4^n·(N+1) peripheral cycles. It also makes a bit-time strobe every 372 card-clock periods, which gives a bit rate of Pφ / (1488·2^(2n−1)·(N+1)). The card clock reaches its pin only while the clock enable is set. The bit timing keeps running when the enable is clear.

A receiver marks the start of an incoming character with a one-cycle sync input. The bit timer then realigns to the card clock and gives a half-bit strobe after 186 card-clock periods, for sampling in the middle of the bit. Any change on the divisor or the prescale select restarts the whole chain from zero. This block is the only clock source for the link.

Top module: `sc_clkgen`

## Requirements
- R1: While `rst` is high at a clock edge, `card_clk`, `bit_tick` and `half_tick` are low after that edge, and every counter returns to zero.
- R2: Let H = 4^n·(N+1), with n = `pre_sel` and N = `div_n`, and let clock edge 1 be the first edge after reset or restart. With `clk_en` high, `card_clk` rises after edge H and falls after edge 2H. It toggles every H edges, so its period is 2H and its duty cycle is 50 %.
- R3: While `clk_en` was low at an edge, `card_clk` is low after that edge. `bit_tick` keeps its normal schedule.
- R4: `bit_tick` is high for exactly one cycle. It first appears after edge 744·H, and then every 744·H cycles, which is 372 card-clock periods.
- R5: A change of `div_n` or of `pre_sel` makes the next edge a restart edge. After it, `card_clk` and `bit_tick` are low, and timing follows R2 and R4 with edges counted from the restart edge.
- R6: When `rx_sync` is high at edge s, the 372-period count and the half-bit count are cleared. The card clock is not affected. Let F be the first multiple of 2H above s. `half_tick` pulses for one cycle after edge F + 185·2H, and `bit_tick` after edge F + 371·2H.
- R7: `half_tick` fires once per sync and never in the same cycle as `bit_tick`.
- R8: A new `rx_sync` while a half-bit count is running restarts that count from the new sync, so only one `half_tick` results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_n | input | 8 | Divisor N (0..255) |
| pre_sel | input | 2 | Prescale select n (0..3) |
| clk_en | input | 1 | Card clock output enable |
| rx_sync | input | 1 | One-cycle receive start marker |
| card_clk | output | 1 | Card clock, registered |
| bit_tick | output | 1 | One-cycle strobe per bit time |
| half_tick | output | 1 | One-cycle mid-bit strobe after a sync |

## Verification
The hardest situation to reach is a receive sync that lands partway through a card-clock period, followed by a second sync while the first half-bit count is still running. The bench runs a fast setting (H = 1), places the first sync on an edge that is itself a period end, and places the second sync on an odd edge. It then predicts the half-bit and bit strobes from the next period boundary. Restarts on a configuration change are reached by changing the divisor alone and, separately, the prescale select alone, partway through a running bit.

// File: rtl/sc_clkgen_pkg.sv
package sc_clkgen_pkg;
  // Prescale limit for select value sel: 4^sel - 1
  function automatic int unsigned pre_limit(input int unsigned sel);
    return (32'd1 << (2 * sel)) - 32'd1;
  endfunction
endpackage

// File: rtl/scg_prescaler.sv
module scg_prescaler #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_n,
  input  logic [SEL_W-1:0] pre_sel,
  output logic             half_edge
);
  import sc_clkgen_pkg::*;

  localparam int NSEL  = 2 ** SEL_W;
  localparam int PRE_W = 2 * (NSEL - 1);

  logic [PRE_W-1:0] lim_tab [NSEL];
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_wrap;
  logic             div_wrap;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = PRE_W'(pre_limit(g));
  end

  assign pre_wrap  = (pre_cnt == lim_tab[pre_sel]);
  assign div_wrap  = (div_cnt == div_n);
  assign half_edge = pre_wrap && div_wrap;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scg_phase.sv
module scg_phase (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic half_edge,
  input  logic clk_en,
  output logic period_end,
  output logic card_clk
);
  logic phase;
  logic phase_nxt;

  assign phase_nxt  = phase ^ half_edge;
  assign period_end = half_edge && phase;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase    <= 1'b0;
      card_clk <= 1'b0;
    end else begin
      phase    <= phase_nxt;
      card_clk <= clk_en && phase_nxt;
    end
  end
endmodule

// File: rtl/scg_bit_timer.sv
module scg_bit_timer #(
  parameter int PERIODS_PER_BIT = 372
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic period_end,
  input  logic rx_sync,
  output logic bit_tick,
  output logic half_tick
);
  localparam int HALF_PERIODS = PERIODS_PER_BIT / 2;
  localparam int CW           = $clog2(PERIODS_PER_BIT);

  logic [CW-1:0] per_cnt;
  logic [CW-1:0] half_cnt;
  logic          armed;
  logic          clear;

  assign clear = rst || restart;

  always_ff @(posedge clk) begin
    if (clear || rx_sync) begin
      per_cnt  <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= period_end && (per_cnt == CW'(PERIODS_PER_BIT - 1));
      if (period_end)
        per_cnt <= (per_cnt == CW'(PERIODS_PER_BIT - 1)) ? '0 : per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      armed     <= 1'b0;
      half_cnt  <= '0;
      half_tick <= 1'b0;
    end else if (rx_sync) begin
      armed     <= 1'b1;
      half_cnt  <= '0;
      half_tick <= 1'b0;
    end else begin
      half_tick <= 1'b0;
      if (armed && period_end) begin
        if (half_cnt == CW'(HALF_PERIODS - 1)) begin
          armed     <= 1'b0;
          half_tick <= 1'b1;
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sc_clkgen.sv
module sc_clkgen #(
  parameter int DIV_W           = 8,
  parameter int SEL_W           = 2,
  parameter int PERIODS_PER_BIT = 372
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_n,
  input  logic [SEL_W-1:0] pre_sel,
  input  logic             clk_en,
  input  logic             rx_sync,
  output logic             card_clk,
  output logic             bit_tick,
  output logic             half_tick
);
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic             restart;
  logic             half_edge;
  logic             period_end;

  assign restart = (div_n != div_q) || (pre_sel != sel_q);

  always_ff @(posedge clk) begin
    div_q <= div_n;
    sel_q <= pre_sel;
  end

  scg_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart),
    .div_n(div_n), .pre_sel(pre_sel), .half_edge(half_edge)
  );

  scg_phase u_phase (
    .clk(clk), .rst(rst), .restart(restart), .half_edge(half_edge),
    .clk_en(clk_en), .period_end(period_end), .card_clk(card_clk)
  );

  scg_bit_timer #(.PERIODS_PER_BIT(PERIODS_PER_BIT)) u_bit (
    .clk(clk), .rst(rst), .restart(restart), .period_end(period_end),
    .rx_sync(rx_sync), .bit_tick(bit_tick), .half_tick(half_tick)
  );
endmodule

// File: rtl/sc_clkgen_chk.sv
module sc_clkgen_chk #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div_n,
  input logic [SEL_W-1:0] pre_sel,
  input logic             clk_en,
  input logic             card_clk,
  input logic             bit_tick,
  input logic             half_tick
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!card_clk && !bit_tick && !half_tick));

  // R3
  a_r3_gated_low: assert property (@(posedge clk) disable iff (rst)
    !$past(clk_en) |-> !card_clk);

  // R4
  a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);

  // R5
  a_r5_cfg_restart: assert property (@(posedge clk) disable iff (rst)
    ((div_n != $past(div_n)) || (pre_sel != $past(pre_sel))) |=> (!card_clk && !bit_tick));

  // R7
  a_r7_half_single: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> !half_tick);

  // R7
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(half_tick && bit_tick));
endmodule

bind sc_clkgen sc_clkgen_chk #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .div_n(div_n), .pre_sel(pre_sel), .clk_en(clk_en),
  .card_clk(card_clk), .bit_tick(bit_tick), .half_tick(half_tick)
);

// File: tb/sc_clkgen_bench.sv
`timescale 1ns/1ps
module sc_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_n = 8'd0;
  logic [1:0] pre_sel = 2'd0;
  logic       clk_en = 1'b1;
  logic       rx_sync = 1'b0;
  logic       card_clk, bit_tick, half_tick;

  always #2.5 clk = ~clk;

  sc_clkgen u_sc_clkgen (
    .clk(clk), .rst(rst), .div_n(div_n), .pre_sel(pre_sel), .clk_en(clk_en),
    .rx_sync(rx_sync), .card_clk(card_clk), .bit_tick(bit_tick), .half_tick(half_tick)
  );

  int n_chk = 0;
  int n_fail = 0;

  // edge counter and observation records
  int ek, rise_e, fall_e, bt1_e, bt2_e, half_e, half_cnt;
  bit clk_seen, wide_bt, prev_bt, overlap;

  // columns: sel, N, clk_en, check second tick
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{0, 0, 1, 1}, '{0, 2, 1, 1}, '{1, 0, 0, 1},
    '{1, 4, 1, 0}, '{2, 0, 1, 0}, '{3, 0, 1, 0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_rec();
    ek = 0; rise_e = -1; fall_e = -1; bt1_e = -1; bt2_e = -1;
    half_e = -1; half_cnt = 0; clk_seen = 0; wide_bt = 0; prev_bt = 0; overlap = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ek++;
    if (card_clk) clk_seen = 1;
    if (card_clk && rise_e < 0) rise_e = ek;
    if (!card_clk && rise_e >= 0 && fall_e < 0) fall_e = ek;
    if (bit_tick && prev_bt) wide_bt = 1;
    if (bit_tick && !prev_bt) begin
      if (bt1_e < 0) bt1_e = ek;
      else if (bt2_e < 0) bt2_e = ek;
    end
    prev_bt = bit_tick;
    if (half_tick) begin
      half_cnt++;
      if (half_e < 0) half_e = ek;
    end
    if (half_tick && bit_tick) overlap = 1;
  endtask

  task automatic do_reset(input int sel, input int nv, input bit en);
    @(negedge clk);
    rst = 1'b1; pre_sel = 2'(sel); div_n = 8'(nv); clk_en = en;
    @(posedge clk); @(negedge clk);
    chk(!card_clk && !bit_tick && !half_tick, "R1 reset outputs", {card_clk, bit_tick, half_tick}, 0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    clear_rec();
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h, s1, s2, f, limit;

    // table walk: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      h = (1 << (2 * VEC[v][0])) * (VEC[v][1] + 1);
      do_reset(VEC[v][0], VEC[v][1], VEC[v][2] != 0);
      limit = (VEC[v][3] != 0) ? 1488 * h + 2 : 744 * h + 2;
      while (ek < limit) step();
      if (VEC[v][2] != 0) begin
        chk(rise_e == h, "R2 first rise", rise_e, h);
        chk(fall_e == 2 * h, "R2 first fall", fall_e, 2 * h);
      end else begin
        chk(!clk_seen, "R3 gated clock low", clk_seen, 0);
      end
      chk(bt1_e == 744 * h, "R4 first bit tick", bt1_e, 744 * h);
      chk(!wide_bt, "R4 tick width", wide_bt, 0);
      if (VEC[v][3] != 0)
        chk(bt2_e == 1488 * h, "R4 tick spacing", bt2_e, 1488 * h);
    end

    // R5: divisor change restarts
    do_reset(0, 0, 1);
    while (ek < 100) step();
    div_n = 8'd1;
    clear_rec();
    step();
    chk(!card_clk && !bit_tick, "R5 low after divisor change", card_clk, 0);
    clear_rec();
    while (ek < 1490) step();
    chk(rise_e == 2, "R5 rise after divisor change", rise_e, 2);
    chk(bt1_e == 1488, "R5 tick after divisor change", bt1_e, 1488);

    // R5: prescale select change restarts
    while (ek < 1600) step();
    pre_sel = 2'd1;
    clear_rec();
    step();
    chk(!card_clk, "R5 low after select change", card_clk, 0);
    clear_rec();
    while (ek < 5954) step();
    chk(rise_e == 8, "R5 rise after select change", rise_e, 8);
    chk(bt1_e == 5952, "R5 tick after select change", bt1_e, 5952);

    // R6, R7: sync on a period-end edge, H = 1
    do_reset(0, 0, 1);
    while (ek < 5) step();
    rx_sync = 1'b1;
    step();
    rx_sync = 1'b0;
    s1 = ek;
    f = (s1 / 2 + 1) * 2;
    while (ek < f + 371 * 2 + 400) step();
    chk(half_e == f + 185 * 2, "R6 half tick after sync", half_e, f + 370);
    chk(bt1_e == f + 371 * 2, "R6 bit tick after sync", bt1_e, f + 742);
    chk(half_cnt == 1, "R7 single half tick", half_cnt, 1);
    chk(!overlap, "R7 no overlap", overlap, 0);

    // R8: second sync while armed
    do_reset(0, 0, 1);
    while (ek < 5) step();
    rx_sync = 1'b1;
    step();
    rx_sync = 1'b0;
    while (ek < 100) step();
    rx_sync = 1'b1;
    step();
    rx_sync = 1'b0;
    s2 = ek;
    f = (s2 / 2 + 1) * 2;
    while (ek < f + 371 * 2 + 10) step();
    chk(half_e == f + 185 * 2, "R8 half tick from second sync", half_e, f + 370);
    chk(half_cnt == 1, "R8 one half tick", half_cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule